// File: doc/BRIEF.md
# Dedicated-Pin Board Test Controller

This block lets software take direct control of dedicated pins, meaning pins that have no general-purpose I/O function, so that board connections can be tested in the system. It sits between a simple register bus and the pad drivers. The bus has an address, write data, a write strobe and combinational read data. In normal operation every pad's output value and output enable pass straight through from the functional logic. Once test mode is unlocked, the pads are instead driven from a bank of test data registers. Each register holds four pad bits, and each register has its own output enable. The value written to a register appears on its pins inverted.

Entering test mode takes two consecutive bus writes to the key address: first an arming key, then a firing key. Any other write in between cancels the sequence, so a single stray write can never switch the pins over. Each data register also has a read-source select. With the select clear, reading the register returns the live pad levels, taken through a two-flop synchroniser. With the select set, the read returns the stored bits.

Top module: `padtest_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `test_mode` is 0 and all data bits, output enables and read-source selects are 0. Reading any register returns 0.
- R2: While `test_mode` is 0, `pad_out` equals `func_out` and `pad_oe` equals `func_oe` for every pad, whatever has been written to the test registers.
- R3: `test_mode` becomes 1 one cycle after a write of 0x0000_5A5A to address 0x0. This only happens when the previous bus write was 0x0000_A5A5 to address 0x0. A lone 0x0000_5A5A write leaves test mode off.
- R4: The sequence is cancelled by any bus write between the arming write and the firing write, whether it has a different address or a different value on address 0x0. A repeated arming write re-arms the sequence.
- R5: A write of 0x0000_0000 to address 0x0 clears `test_mode` on the next cycle. Other writes do not clear it.
- R6: In test mode, pad 4n+b is driven to the inverse of bit b of data register n. Data register n sits at address 0x4+n, with its bits in write data [3:0].
- R7: In test mode, all four pads of register n have `pad_oe` equal to output-enable bit n. The control register at address 0x1 holds the output enables in bits [3:0] and the read-source selects in bits [7:4]; bit 4+n belongs to register n.
- R8: When the read-source select of register n is 0, reading address 0x4+n returns `pad_in[4n+3:4n]` in bits [3:0], with the upper bits 0. The value returned is the pad level sampled two clock edges earlier.
- R9: When the read-source select of register n is 1, reading address 0x4+n returns the stored register bits.
- R10: Reading address 0x0 returns `test_mode` in bit 0. Reading address 0x1 returns the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| func_out | input | 16 | Output values from the functional logic |
| func_oe | input | 16 | Output enables from the functional logic |
| pad_in | input | 16 | Levels seen on the pins |
| pad_out | output | 16 | Output value to the pad drivers |
| pad_oe | output | 16 | Output enable to the pad drivers |
| test_mode | output | 1 | Test mode active |

## Verification
The bench attacks the unlock sequence with a lone firing key, interrupted pairs, a foreign value on the key address and a re-armed pair. A design that checks only the last write would enter test mode on noise, and one that never clears the armed state would unlock after an unrelated write. It sweeps every nibble through every data register and every output-enable pattern. A missing inversion, or an enable wired to the wrong group, would show up directly at the pads. It also measures the synchroniser latency edge by edge, and mixes read-source selects across registers, which catches a wrong number of stages or selects swapped between registers.

// File: rtl/padtest_pkg.sv
package padtest_pkg;
    localparam int unsigned BUS_DW     = 32;
    localparam int unsigned ADDR_KEY   = 0;
    localparam int unsigned ADDR_CTRL  = 1;
    localparam int unsigned ADDR_DATA0 = 4;
    localparam logic [BUS_DW-1:0] KEY_ARM   = 32'h0000_A5A5;
    localparam logic [BUS_DW-1:0] KEY_FIRE  = 32'h0000_5A5A;
    localparam logic [BUS_DW-1:0] KEY_CLEAR = 32'h0000_0000;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_e;
endpackage

// File: rtl/padtest_unlock.sv
module padtest_unlock
    import padtest_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_DW-1:0] wr_data,
    output logic              mode_en
);
    localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(ADDR_KEY);

    typedef struct packed {
        seq_e seq;
        logic en;
    } unlock_t;

    unlock_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == KEY_A) begin
                if (wr_data == KEY_ARM) begin
                    st_d.seq = SEQ_ARMED;
                end else if (st_q.seq == SEQ_ARMED && wr_data == KEY_FIRE) begin
                    st_d.seq = SEQ_IDLE;
                    st_d.en  = 1'b1;
                end else begin
                    st_d.seq = SEQ_IDLE;
                    if (wr_data == KEY_CLEAR) begin
                        st_d.en = 1'b0;
                    end
                end
            end else begin
                st_d.seq = SEQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{seq: SEQ_IDLE, en: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_en = st_q.en;
endmodule

// File: rtl/padtest_sync.sv
module padtest_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_t;

    sync_t st_q, st_d;

    always_comb begin
        st_d.pipe[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.pipe[STAGES-1];
endmodule

// File: rtl/padtest_regs.sv
module padtest_regs
    import padtest_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned REG_BITS = 4,
    localparam int unsigned NUM_PADS = NUM_REGS * REG_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BUS_DW-1:0]   wdata,
    input  logic                mode_en,
    input  logic [NUM_PADS-1:0] pad_sync,
    output logic [NUM_PADS-1:0] data_bits,
    output logic [NUM_REGS-1:0] grp_oe,
    output logic [BUS_DW-1:0]   rdata
);
    localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(ADDR_KEY);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(ADDR_CTRL);

    typedef struct packed {
        logic [NUM_REGS-1:0][REG_BITS-1:0] dat;
        logic [NUM_REGS-1:0]               oe;
        logic [NUM_REGS-1:0]               rdsel;
    } regs_t;

    regs_t st_q, st_d;

    logic unused_wdata_hi;
    assign unused_wdata_hi = &{1'b0, wdata};

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (addr == CTRL_A) begin
                st_d.oe    = wdata[NUM_REGS-1:0];
                st_d.rdsel = wdata[2*NUM_REGS-1:NUM_REGS];
            end
            for (int n = 0; n < NUM_REGS; n++) begin
                if (addr == ADDR_W'(ADDR_DATA0 + n)) begin
                    st_d.dat[n] = wdata[REG_BITS-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == KEY_A) begin
            rdata[0] = mode_en;
        end
        if (addr == CTRL_A) begin
            rdata[2*NUM_REGS-1:0] = {st_q.rdsel, st_q.oe};
        end
        for (int n = 0; n < NUM_REGS; n++) begin
            if (addr == ADDR_W'(ADDR_DATA0 + n)) begin
                rdata[REG_BITS-1:0] = st_q.rdsel[n] ? st_q.dat[n]
                                                    : pad_sync[n*REG_BITS +: REG_BITS];
            end
        end
    end

    assign data_bits = st_q.dat;
    assign grp_oe    = st_q.oe;
endmodule

// File: rtl/padtest_padmux.sv
module padtest_padmux #(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned REG_BITS = 4,
    localparam int unsigned NUM_PADS = NUM_REGS * REG_BITS
) (
    input  logic                mode_en,
    input  logic [NUM_PADS-1:0] data_bits,
    input  logic [NUM_REGS-1:0] grp_oe,
    input  logic [NUM_PADS-1:0] func_out,
    input  logic [NUM_PADS-1:0] func_oe,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe
);
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        localparam int unsigned GRP = p / REG_BITS;
        assign pad_out[p] = mode_en ? ~data_bits[p] : func_out[p];
        assign pad_oe[p]  = mode_en ? grp_oe[GRP]   : func_oe[p];
    end
endmodule

// File: rtl/padtest_ctrl.sv
module padtest_ctrl
    import padtest_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned NUM_REGS    = 4,
    parameter int unsigned REG_BITS    = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned NUM_PADS   = NUM_REGS * REG_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_DW-1:0]   bus_wdata,
    input  logic                bus_we,
    output logic [BUS_DW-1:0]   bus_rdata,
    input  logic [NUM_PADS-1:0] func_out,
    input  logic [NUM_PADS-1:0] func_oe,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic                test_mode
);
    logic                mode_en;
    logic [NUM_PADS-1:0] pad_sync;
    logic [NUM_PADS-1:0] data_bits;
    logic [NUM_REGS-1:0] grp_oe;

    padtest_unlock #(.ADDR_W(ADDR_W)) u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .mode_en (mode_en)
    );

    padtest_sync #(.WIDTH(NUM_PADS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pad_sync)
    );

    padtest_regs #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .REG_BITS(REG_BITS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .mode_en   (mode_en),
        .pad_sync  (pad_sync),
        .data_bits (data_bits),
        .grp_oe    (grp_oe),
        .rdata     (bus_rdata)
    );

    padtest_padmux #(.NUM_REGS(NUM_REGS), .REG_BITS(REG_BITS)) u_mux (
        .mode_en   (mode_en),
        .data_bits (data_bits),
        .grp_oe    (grp_oe),
        .func_out  (func_out),
        .func_oe   (func_oe),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    assign test_mode = mode_en;
endmodule

// File: rtl/padtest_checker.sv
module padtest_checker
    import padtest_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned NUM_PADS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [BUS_DW-1:0]   bus_wdata,
    input logic                bus_we,
    input logic [BUS_DW-1:0]   bus_rdata,
    input logic [NUM_PADS-1:0] func_out,
    input logic [NUM_PADS-1:0] func_oe,
    input logic [NUM_PADS-1:0] pad_out,
    input logic [NUM_PADS-1:0] pad_oe,
    input logic                test_mode
);
    localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(ADDR_KEY);

    logic clear_wr;
    assign clear_wr = bus_we && bus_addr == KEY_A && bus_wdata == KEY_CLEAR;

    AST_FUNC_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> (pad_out == func_out && pad_oe == func_oe)); // R2

    AST_ENTRY_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> $past(bus_we && bus_addr == KEY_A && bus_wdata == KEY_FIRE)); // R3

    AST_CLEAR_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        clear_wr |=> !test_mode); // R5

    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && !clear_wr) |=> test_mode); // R5

    AST_KEY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == KEY_A |-> bus_rdata == {31'b0, test_mode}); // R10
endmodule

bind padtest_ctrl padtest_checker #(.ADDR_W(ADDR_W), .NUM_PADS(NUM_PADS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .func_out  (func_out),
    .func_oe   (func_oe),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .test_mode (test_mode)
);

// File: tb/padtest_ctrl_bench.sv
`timescale 1ns/1ps
module padtest_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [15:0] func_out = '0, func_oe = '0, pad_in = '0;
    logic [15:0] pad_out, pad_oe;
    logic        test_mode;

    int n_chk = 0, n_fail = 0;
    logic [3:0] mdl_dat [4];

    always #5 clk = ~clk;

    padtest_ctrl u_padtest_ctrl (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic unlock();
        wr(4'h0, 32'h0000_A5A5);
        wr(4'h0, 32'h0000_5A5A);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        finish_up();
    end

    initial begin
        logic [31:0] r;
        logic [15:0] exp_out;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(test_mode == 1'b0, "R1 mode", {31'b0, test_mode}, 0);
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), r);
            check(r == 0, "R1 read", r, 0);
        end

        // R2 pass-through with registers loaded while disabled
        wr(4'h1, 32'hFF);
        for (int n = 0; n < 4; n++) wr(4'(4 + n), 32'hA);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            func_out = 16'(k * 16'h1357 + 16'h0F0F);
            func_oe  = 16'(k * 16'h2468 + 16'h5555);
            #1;
            check(pad_out == func_out, "R2 out", pad_out, func_out);
            check(pad_oe == func_oe, "R2 oe", pad_oe, func_oe);
        end
        wr(4'h1, 32'h0);
        for (int n = 0; n < 4; n++) wr(4'(4 + n), 32'h0);

        // R3 lone firing key
        wr(4'h0, 32'h0000_5A5A);
        check(test_mode == 1'b0, "R3 lone fire", {31'b0, test_mode}, 0);
        // R4 interrupted by other address
        wr(4'h0, 32'h0000_A5A5);
        wr(4'h1, 32'h0);
        wr(4'h0, 32'h0000_5A5A);
        check(test_mode == 1'b0, "R4 other addr", {31'b0, test_mode}, 0);
        // R4 interrupted by other value on key address
        wr(4'h0, 32'h0000_A5A5);
        wr(4'h0, 32'h0000_1234);
        wr(4'h0, 32'h0000_5A5A);
        check(test_mode == 1'b0, "R4 other value", {31'b0, test_mode}, 0);
        // R4 re-arm then fire
        wr(4'h0, 32'h0000_A5A5);
        wr(4'h0, 32'h0000_A5A5);
        wr(4'h0, 32'h0000_5A5A);
        check(test_mode == 1'b1, "R4 rearm", {31'b0, test_mode}, 1);
        rd(4'h0, r);
        check(r == 1, "R10 key read", r, 1);
        // R5 non-clear write keeps, clear exits
        wr(4'h0, 32'h0000_1111);
        check(test_mode == 1'b1, "R5 keep", {31'b0, test_mode}, 1);
        wr(4'h0, 32'h0);
        check(test_mode == 1'b0, "R5 clear", {31'b0, test_mode}, 0);
        rd(4'h0, r);
        check(r == 0, "R10 key read off", r, 0);
        // R3 proper unlock
        unlock();
        check(test_mode == 1'b1, "R3 unlock", {31'b0, test_mode}, 1);

        // R6 every nibble in every register, func inputs ignored
        for (int n = 0; n < 4; n++) mdl_dat[n] = 4'h0;
        for (int n = 0; n < 4; n++) begin
            for (int v = 0; v < 16; v++) begin
                wr(4'(4 + n), 32'hFFFF_FFF0 | 32'(v));
                mdl_dat[n] = 4'(v);
                func_out = ~func_out;
                #1;
                exp_out = ~{mdl_dat[3], mdl_dat[2], mdl_dat[1], mdl_dat[0]};
                check(pad_out == exp_out, "R6 invert", pad_out, exp_out);
            end
        end

        // R7 every output-enable pattern
        for (int m = 0; m < 16; m++) begin
            logic [15:0] e;
            wr(4'h1, 32'(m));
            #1;
            for (int p = 0; p < 16; p++) e[p] = m[p / 4];
            check(pad_oe == e, "R7 group oe", pad_oe, e);
            rd(4'h1, r);
            check(r == 32'(m), "R10 ctrl read", r, m);
        end

        // R8 synchroniser latency, select 0
        wr(4'h1, 32'h0);
        @(negedge clk);
        pad_in = 16'h0000;
        repeat (3) @(negedge clk);
        pad_in = 16'hBEEF;
        @(negedge clk);
        rd(4'h4, r);
        check(r == 0, "R8 one edge old", r, 0);
        @(negedge clk);
        rd(4'h4, r);
        check(r == 32'hF, "R8 two edges new", r, 32'hF);

        // R8 pattern sweep
        for (int k = 0; k < 16; k++) begin
            pad_in = 16'(k * 16'h3B5D + 16'h00C3);
            repeat (2) @(negedge clk);
            for (int n = 0; n < 4; n++) begin
                logic [31:0] e;
                e = 32'((pad_in >> (4 * n)) & 16'hF);
                rd(4'(4 + n), r);
                check(r == e, "R8 pad level", r, e);
            end
        end

        // R9 mixed selects
        for (int s = 0; s < 16; s++) begin
            wr(4'h1, 32'(s << 4));
            for (int n = 0; n < 4; n++) begin
                logic [31:0] e;
                e = s[n] ? 32'(mdl_dat[n]) : 32'((pad_in >> (4 * n)) & 16'hF);
                rd(4'(4 + n), r);
                check(r == e, s[n] ? "R9 stored" : "R8 mixed", r, e);
            end
        end

        // R2 after leaving test mode
        wr(4'h0, 32'h0);
        #1;
        check(pad_out == func_out, "R2 after exit", pad_out, func_out);

        // R1 reset clears everything
        @(negedge clk);
        unlock();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(test_mode == 1'b0, "R1 reset mode", {31'b0, test_mode}, 0);
        rd(4'h1, r);
        check(r == 0, "R1 reset ctrl", r, 0);
        wr(4'h1, 32'hF0);
        rd(4'h5, r);
        check(r == 0, "R1 reset data", r, 0);

        finish_up();
    end
endmodule